// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the main control unit of a single-cycle processor with a 32-bit, three-format instruction set. It looks only at the 6-bit major opcode of the current instruction and, with no clock and no state, drives every steering signal that the datapath needs in that cycle. These are the register-write destination select, the second ALU operand select, the write-back source select, the register-file and data-memory enables, the equal and not-equal branch flags, the jump select, the immediate extender mode and a 2-bit ALU operation class that a separate ALU decoder refines.

Register-register ALU operations, five immediate ALU forms (add, set-less-than, and, or, xor), word load, word store, branch-on-equal, branch-on-not-equal and the unconditional jump are recognised. Each datapath multiplexer gets its own one-bit select from this decoder. Any other opcode turns every output off, so an unknown instruction writes nothing, reads nothing and leaves the program counter on its sequential path. The output vector order used below is {reg_dst, alu_src, wb_from_mem, reg_we, mem_rd, mem_we, br_eq, br_ne, jump, ext_signed, alu_class[1:0]}.

Top module: `main_ctrl_dec`

## Requirements
- R1: Each recognised opcode produces exactly this 12-bit vector: 0x00 → 1001_0000_0010, 0x02 → 0000_0000_1000, 0x04 → 0000_0010_0101, 0x05 → 0000_0001_0101, 0x08 → 0101_0000_0100, 0x0A → 0101_0000_0111, 0x0C/0x0D/0x0E → 0101_0000_0011, 0x23 → 0111_1000_0100, 0x2B → 0100_0100_0100.
- R2: Opcode 0x00 (register-register) sets reg_dst=1, reg_we=1, alu_src=0 and alu_class=2'b10 (use the function field). No other opcode sets reg_dst.
- R3: The immediate ALU opcodes 0x08, 0x0A, 0x0C, 0x0D and 0x0E, and the load 0x23, set alu_src=1, reg_dst=0 and reg_we=1.
- R4: ext_signed is 1 for 0x08, 0x0A, 0x23, 0x2B, 0x04 and 0x05. It is 0 for 0x0C, 0x0D and 0x0E (zero extension) and for every other opcode.
- R5: wb_from_mem and mem_rd are 1 only for the load opcode 0x23.
- R6: mem_we is 1 only for the store opcode 0x2B. The store, both branches and the jump leave reg_we at 0.
- R7: br_eq is 1 only for 0x04 and br_ne only for 0x05. Both branches use alu_class=2'b01 (subtract and compare). At most one of br_eq, br_ne and jump is ever 1.
- R8: jump is 1 only for opcode 0x02.
- R9: Every opcode not listed in R1 drives all twelve output bits to 0.
- R10: alu_class is 2'b00 (add) for 0x08, 0x23 and 0x2B. It is 2'b11 (operation taken from the opcode) for 0x0A, 0x0C, 0x0D and 0x0E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Major opcode field of the current instruction |
| reg_dst | output | 1 | 1: write the rd field register, 0: write the rt field register |
| alu_src | output | 1 | 1: the second ALU operand is the extended immediate |
| wb_from_mem | output | 1 | 1: write-back data comes from data memory |
| reg_we | output | 1 | Register-file write enable |
| mem_rd | output | 1 | Data-memory read enable |
| mem_we | output | 1 | Data-memory write enable |
| br_eq | output | 1 | Take the branch target when the operands are equal |
| br_ne | output | 1 | Take the branch target when the operands differ |
| jump | output | 1 | Select the jump target for the next program counter |
| ext_signed | output | 1 | 1: sign-extend the 16-bit immediate, 0: zero-extend it |
| alu_class | output | 2 | 00 add, 01 subtract/compare, 10 function field, 11 from opcode |

## Verification
The case that is hardest to reach from the ports is the quiet response to the many opcodes that sit next to legal ones, such as 0x03, 0x06, 0x09, 0x0F and 0x2A. A single wrong bit in the decode of one of them would let an unknown instruction write a register or memory. The stimulus therefore sweeps all 64 opcode values and checks both the full vector and each field rule against the requirement it comes from. The eleven legal opcodes are first walked through a table of expected vectors.

// File: rtl/main_ctrl_dec.sv
module main_ctrl_dec #(
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] opcode,
  output logic           reg_dst,
  output logic           alu_src,
  output logic           wb_from_mem,
  output logic           reg_we,
  output logic           mem_rd,
  output logic           mem_we,
  output logic           br_eq,
  output logic           br_ne,
  output logic           jump,
  output logic           ext_signed,
  output logic [1:0]     alu_class
);

  localparam logic [OPW-1:0] OP_RRR  = OPW'(6'h00);
  localparam logic [OPW-1:0] OP_JMP  = OPW'(6'h02);
  localparam logic [OPW-1:0] OP_BEQ  = OPW'(6'h04);
  localparam logic [OPW-1:0] OP_BNE  = OPW'(6'h05);
  localparam logic [OPW-1:0] OP_ADDI = OPW'(6'h08);
  localparam logic [OPW-1:0] OP_SLTI = OPW'(6'h0A);
  localparam logic [OPW-1:0] OP_ANDI = OPW'(6'h0C);
  localparam logic [OPW-1:0] OP_ORI  = OPW'(6'h0D);
  localparam logic [OPW-1:0] OP_XORI = OPW'(6'h0E);
  localparam logic [OPW-1:0] OP_LOAD = OPW'(6'h23);
  localparam logic [OPW-1:0] OP_STOR = OPW'(6'h2B);

  localparam int VW = 12;

  logic [VW-1:0] ctl;

  always_comb begin
    unique case (opcode)
      OP_RRR:  ctl = 12'b1001_0000_0010;
      OP_JMP:  ctl = 12'b0000_0000_1000;
      OP_BEQ:  ctl = 12'b0000_0010_0101;
      OP_BNE:  ctl = 12'b0000_0001_0101;
      OP_ADDI: ctl = 12'b0101_0000_0100;
      OP_SLTI: ctl = 12'b0101_0000_0111;
      OP_ANDI, OP_ORI, OP_XORI:
               ctl = 12'b0101_0000_0011;
      OP_LOAD: ctl = 12'b0111_1000_0100;
      OP_STOR: ctl = 12'b0100_0100_0100;
      default: ctl = '0;
    endcase
  end

  assign {reg_dst, alu_src, wb_from_mem, reg_we, mem_rd, mem_we,
          br_eq, br_ne, jump, ext_signed, alu_class} = ctl;

  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_one_pc_source_R7: assert ($onehot0({br_eq, br_ne, jump}))
        else $error("more than one next-pc source selected");
      assert_branch_compare_R7: assert (!(br_eq || br_ne) || alu_class == 2'b01)
        else $error("branch without compare class");
      assert_store_no_wb_R6: assert (!mem_we || (!reg_we && !mem_rd))
        else $error("store also writes back or reads");
      assert_load_pair_R5: assert (mem_rd == wb_from_mem)
        else $error("load read and write-back source disagree");
      assert_rd_dest_R2: assert (!reg_dst || (reg_we && !alu_src && alu_class == 2'b10))
        else $error("rd destination without register-register form");
      assert_no_side_effect_R9: assert (!(jump || br_eq || br_ne) || (!reg_we && !mem_we))
        else $error("control transfer with a write enable");
    end
  end

endmodule

// File: tb/main_ctrl_dec_bench.sv
module main_ctrl_dec_bench;

  localparam int PERIOD = 10;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [5:0] opcode;
  logic reg_dst, alu_src, wb_from_mem, reg_we, mem_rd, mem_we;
  logic br_eq, br_ne, jump, ext_signed;
  logic [1:0] alu_class;

  main_ctrl_dec u_main_ctrl_dec (
    .opcode(opcode), .reg_dst(reg_dst), .alu_src(alu_src),
    .wb_from_mem(wb_from_mem), .reg_we(reg_we), .mem_rd(mem_rd),
    .mem_we(mem_we), .br_eq(br_eq), .br_ne(br_ne), .jump(jump),
    .ext_signed(ext_signed), .alu_class(alu_class)
  );

  localparam logic [17:0] VEC [NV] = '{
    {6'h00, 12'b1001_0000_0010},
    {6'h02, 12'b0000_0000_1000},
    {6'h04, 12'b0000_0010_0101},
    {6'h05, 12'b0000_0001_0101},
    {6'h08, 12'b0101_0000_0100},
    {6'h0A, 12'b0101_0000_0111},
    {6'h0C, 12'b0101_0000_0011},
    {6'h0D, 12'b0101_0000_0011},
    {6'h0E, 12'b0101_0000_0011},
    {6'h23, 12'b0111_1000_0100},
    {6'h2B, 12'b0100_0100_0100}
  };

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [11:0] outv();
    return {reg_dst, alu_src, wb_from_mem, reg_we, mem_rd, mem_we,
            br_eq, br_ne, jump, ext_signed, alu_class};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp, input logic [5:0] op);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%02h actual=%b expected=%b", req, op, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op);
    @(negedge clk);
    opcode = op;
    #1;
  endtask

  function automatic bit legal(input logic [5:0] op);
    for (int i = 0; i < NV; i++) if (VEC[i][17:12] == op) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    opcode = 6'h3F;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset-state", outv(), 12'h000, opcode);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17:12]);
      chk("R1", outv(), VEC[i][11:0], opcode);
    end

    for (int k = 0; k < 64; k++) begin
      logic [5:0] op;
      bit isimm, sgn;
      op = 6'(k);
      apply(op);
      isimm = (op == 6'h08 || op == 6'h0A || op == 6'h0C || op == 6'h0D || op == 6'h0E);
      sgn = (op == 6'h08 || op == 6'h0A || op == 6'h23 || op == 6'h2B || op == 6'h04 || op == 6'h05);
      if (!legal(op)) chk("R9", outv(), 12'h000, op);
      chk("R2", {11'b0, reg_dst}, {11'b0, op == 6'h00}, op);
      if (op == 6'h00)
        chk("R2", {8'b0, reg_we, alu_src, alu_class}, 12'b0000_0000_1010, op);
      if (isimm || op == 6'h23)
        chk("R3", {9'b0, alu_src, reg_dst, reg_we}, 12'b0000_0000_0101, op);
      chk("R4", {11'b0, ext_signed}, {11'b0, sgn}, op);
      chk("R5", {10'b0, wb_from_mem, mem_rd}, {10'b0, op == 6'h23, op == 6'h23}, op);
      chk("R6", {11'b0, mem_we}, {11'b0, op == 6'h2B}, op);
      if (op == 6'h2B || op == 6'h04 || op == 6'h05 || op == 6'h02)
        chk("R6", {11'b0, reg_we}, 12'h000, op);
      chk("R7", {10'b0, br_eq, br_ne}, {10'b0, op == 6'h04, op == 6'h05}, op);
      if (op == 6'h04 || op == 6'h05)
        chk("R7", {10'b0, alu_class}, 12'b01, op);
      chk("R8", {11'b0, jump}, {11'b0, op == 6'h02}, op);
      if (op == 6'h08 || op == 6'h23 || op == 6'h2B)
        chk("R10", {10'b0, alu_class}, 12'b00, op);
      if (op == 6'h0A || op == 6'h0C || op == 6'h0D || op == 6'h0E)
        chk("R10", {10'b0, alu_class}, 12'b11, op);
    end

    apply(6'h04);
    apply(6'h05);
    chk("R7 beq-to-bne switch", outv(), 12'b0000_0001_0101, opcode);
    apply(6'h01);
    chk("R9 neighbour of jump", outv(), 12'h000, opcode);
    apply(6'h03);
    chk("R9 jump-and-link slot", outv(), 12'h000, opcode);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule